// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block is the configuration-space target of a single PCI function. It covers 256 bytes, seen as 64 dwords, and answers one dword access at a time on a simple request port. A request has a valid strobe, a write flag, a dword index, four byte enables and write data. The response acknowledge and any read data come back exactly one clock later. The standard header lives in dwords 00h to 0Fh, and device-specific registers lie above that.

The block returns the fixed vendor, device, revision and class identification from parameters. All six base address registers read as zero. The interrupt line byte is writable, so firmware can record an assigned IRQ there. The subsystem identifier pair at byte offset 2Ch comes from strap inputs at reset, and a zero strap is swapped for a non-zero parameter default. The header field of the subsystem vendor ID is not directly writable. The `MODE` parameter picks one of two firmware paths for changing it:
- **Mirror mode:** a copy of the vendor ID sits at offset 40h, and a write there updates both the copy and the header field.
- **Write-enable mode:** a control bit at offset 44h opens direct writes to 2Ch.

Every other location is reserved: it reads zero and discards writes.

Top module: `pci_cfg_header`

## Requirements
- R1: A request sampled with `req_valid` high raises `rsp_ack` for exactly the next cycle, and no acknowledge appears without a request. Write responses return zero on `rsp_rdata`.
- R2: A read of a reserved or unimplemented dword returns all zeros. This covers the BAR dwords at byte offsets 10h, 14h, 18h, 1Ch, 20h and 24h, and the device-specific dword the selected mode does not use.
- R3: Dword 00h reads `{DEVICE_ID, VENDOR_ID}`. Dword 08h reads `{CLASS_CODE, REVISION}`, with the class code in bits 31:8.
- R4: After reset, dword 2Ch holds the Subsystem ID in bits 31:16 and the Subsystem Vendor ID in bits 15:0. Each is loaded from its strap, and a strap of zero is replaced by the non-zero parameter default.
- R5: The Subsystem ID in bits 31:16 of 2Ch never changes after reset.
- R6: In mirror mode (`MODE`=0), the dword at 40h holds a copy of the vendor ID in bits 15:0. A write there updates the enabled bytes of both the copy and the field at 2Ch.
- R7: In mirror mode, a direct write to 2Ch leaves the vendor ID unchanged.
- R8: In write-enable mode (`MODE`=1), bit 0 of dword 44h is a gate bit. It resets to 0, is written through byte enable 0, and the other bits of the dword read zero. A write to 2Ch updates the enabled low bytes of the vendor ID only while the gate bit is 1.
- R9: Dword 3Ch holds the interrupt line in bits 7:0, which is writable only through byte enable 0. It holds the constant interrupt pin `INT_PIN` in bits 15:8, and zero in the bits above.
- R10: A write to a reserved dword or a BAR changes nothing that any read can observe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ssid | input | 16 | Subsystem ID strap sampled during reset |
| strap_ssvid | input | 16 | Subsystem vendor ID strap sampled during reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Dword index (byte offset / 4) |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |

## Verification
The assertions assume the straps stay constant for the whole run, so the subsystem ID register never has a reason to differ from its reset value. They also assume only one request is presented per cycle, and that requests are never issued while reset is held. The bench ties both strap pairs to fixed constants: one of them is zero, which exercises the default substitution. It drives the request port only between clock edges, with one idle cycle between accesses. Random addresses, byte enables and data reach every dword, including the gate bit and the mirror, so both firmware paths see partial and full writes.

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID     = 16'h0101,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [23:0] CLASS_CODE    = 24'h028000,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [15:0] SSID_DEFAULT  = 16'h0001,
  parameter logic [15:0] SSVID_DEFAULT = 16'h0F0F,
  parameter int          MODE          = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] strap_ssid,
  input  logic [15:0] strap_ssvid,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_ack,
  output logic [31:0] rsp_rdata
);
  localparam logic [5:0] A_ID     = 6'h00;
  localparam logic [5:0] A_CLASS  = 6'h02;
  localparam logic [5:0] A_SUBSYS = 6'h0B;
  localparam logic [5:0] A_INTR   = 6'h0F;
  localparam logic [5:0] A_MIRROR = 6'h10;
  localparam logic [5:0] A_GATE   = 6'h11;
  localparam bit MIRROR_MODE = (MODE == 0);

  logic [15:0] ssid_q, ssvid_q, mirror_q;
  logic [7:0]  intline_q;
  logic        wen_q;
  logic [31:0] rd_mux;

  wire [15:0] ssid_rst  = (strap_ssid  != 16'h0) ? strap_ssid  : SSID_DEFAULT;
  wire [15:0] ssvid_rst = (strap_ssvid != 16'h0) ? strap_ssvid : SSVID_DEFAULT;
  wire        wr        = req_valid & req_write;
  wire        wr_mirror = wr && MIRROR_MODE && req_addr == A_MIRROR;
  wire        wr_subsys = wr && !MIRROR_MODE && wen_q && req_addr == A_SUBSYS;
  wire        wr_gate   = wr && !MIRROR_MODE && req_addr == A_GATE && req_be[0];
  wire        wr_intr   = wr && req_addr == A_INTR && req_be[0];
  wire [15:0] vid_next  = {req_be[1] ? req_wdata[15:8] : ssvid_q[15:8],
                           req_be[0] ? req_wdata[7:0]  : ssvid_q[7:0]};

  logic unused_bits;
  assign unused_bits = &{1'b0, req_wdata[31:16], req_be[3:2]};

  always_comb begin
    case (req_addr)
      A_ID:     rd_mux = {DEVICE_ID, VENDOR_ID};
      A_CLASS:  rd_mux = {CLASS_CODE, REVISION};
      A_SUBSYS: rd_mux = {ssid_q, ssvid_q};
      A_INTR:   rd_mux = {16'h0, INT_PIN, intline_q};
      A_MIRROR: rd_mux = MIRROR_MODE ? {16'h0, mirror_q} : 32'h0;
      A_GATE:   rd_mux = MIRROR_MODE ? 32'h0 : {31'h0, wen_q};
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssid_q    <= ssid_rst;
      ssvid_q   <= ssvid_rst;
      mirror_q  <= ssvid_rst;
      intline_q <= 8'h0;
      wen_q     <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_ack   <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'h0;
      if (wr_mirror || wr_subsys) ssvid_q <= vid_next;
      if (wr_mirror) mirror_q <= vid_next;
      if (wr_intr) intline_q <= req_wdata[7:0];
      if (wr_gate) wen_q <= req_wdata[0];
    end
  end

  function automatic bit is_impl(input logic [5:0] a);
    return a == A_ID || a == A_CLASS || a == A_SUBSYS || a == A_INTR ||
           (MIRROR_MODE && a == A_MIRROR) || (!MIRROR_MODE && a == A_GATE);
  endfunction

  p_ack_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ack);
  p_no_spurious_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ack);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !is_impl(req_addr)) |=> rsp_rdata == 32'h0);
  p_ssid_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ssid_q != 16'h0);
  p_ssid_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ssid_q));
  p_mirror_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    MIRROR_MODE |-> mirror_q == ssvid_q);
  p_direct_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (MIRROR_MODE && wr && req_addr == A_SUBSYS) |=> $stable(ssvid_q));
  p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!MIRROR_MODE && !wen_q) |=> $stable(ssvid_q));
endmodule

// File: tb/pci_cfg_header_test.sv
module pci_cfg_header_test;
  localparam logic [15:0] VID = 16'hA5C3, DID = 16'h0101, SSID_D = 16'h0001, SSVID_D = 16'h0F0F;
  localparam logic [7:0]  REV = 8'h02, IPIN = 8'h01;
  localparam logic [23:0] CC  = 24'h028000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_addr = 0;
  logic [3:0] req_be = 0;
  logic [31:0] req_wdata = 0;
  logic ack_m, ack_w;
  logic [31:0] rd_m, rd_w;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_ssid [2];
  logic [15:0] m_ssvid [2];
  logic [7:0]  m_int [2];
  logic        m_wen [2];

  always #10 clk = ~clk;

  pci_cfg_header #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CC),
    .INT_PIN(IPIN), .SSID_DEFAULT(SSID_D), .SSVID_DEFAULT(SSVID_D), .MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .strap_ssid(16'h0000), .strap_ssvid(16'h1234),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_ack(ack_m), .rsp_rdata(rd_m));

  pci_cfg_header #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CC),
    .INT_PIN(IPIN), .SSID_DEFAULT(SSID_D), .SSVID_DEFAULT(SSVID_D), .MODE(1)) uut_we (
    .clk(clk), .rst_n(rst_n), .strap_ssid(16'h4321), .strap_ssvid(16'h0000),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_ack(ack_w), .rsp_rdata(rd_w));

  function automatic logic [31:0] exp_rd(int k, logic [5:0] a);
    case (a)
      6'h00: return {DID, VID};
      6'h02: return {CC, REV};
      6'h0B: return {m_ssid[k], m_ssvid[k]};
      6'h0F: return {16'h0, IPIN, m_int[k]};
      6'h10: return (k == 0) ? {16'h0, m_ssvid[k]} : 32'h0;
      6'h11: return (k == 1) ? {31'h0, m_wen[k]} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [5:0] a);
    case (a)
      6'h00, 6'h02: return "R3";
      6'h0B: return "R5";
      6'h0F: return "R9";
      6'h10: return "R6";
      6'h11: return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] merge16(logic [15:0] o, logic [31:0] d, logic [3:0] be);
    return {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(bit w, logic [5:0] a, logic [3:0] be, logic [31:0] d, string tag);
    @(negedge clk);
    check("R1 idle ack", {30'h0, ack_m, ack_w}, 32'h0);
    req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check("R1 ack", {30'h0, ack_m, ack_w}, 32'h3);
    if (!w) begin
      check({tag, " mirror-mode read"}, rd_m, exp_rd(0, a));
      check({tag, " gate-mode read"}, rd_w, exp_rd(1, a));
    end else begin
      check("R1 write rdata", rd_m | rd_w, 32'h0);
      if (a == 6'h0F && be[0]) begin m_int[0] = d[7:0]; m_int[1] = d[7:0]; end
      if (a == 6'h10) m_ssvid[0] = merge16(m_ssvid[0], d, be);
      if (a == 6'h0B && m_wen[1]) m_ssvid[1] = merge16(m_ssvid[1], d, be);
      if (a == 6'h11 && be[0]) m_wen[1] = d[0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_ssid[0] = SSID_D; m_ssvid[0] = 16'h1234;
    m_ssid[1] = 16'h4321; m_ssvid[1] = SSVID_D;
    m_int[0] = 0; m_int[1] = 0; m_wen[0] = 0; m_wen[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset ack", {30'h0, ack_m, ack_w}, 32'h0);
    check("R1 reset rdata", rd_m | rd_w, 32'h0);
    rst_n = 1;
    xfer(0, 6'h0B, 4'hF, 0, "R4");
    xfer(0, 6'h00, 4'hF, 0, "R3");
    xfer(0, 6'h02, 4'hF, 0, "R3");
    xfer(0, 6'h0F, 4'hF, 0, "R9");
    xfer(0, 6'h10, 4'hF, 0, "R6");
    xfer(0, 6'h11, 4'hF, 0, "R8");
    xfer(0, 6'h04, 4'hF, 0, "R2");
    xfer(0, 6'h3F, 4'hF, 0, "R2");
    xfer(1, 6'h04, 4'hF, 32'hFFFF_FFFF, "R10");
    xfer(0, 6'h04, 4'hF, 0, "R10");
    xfer(1, 6'h0B, 4'hF, 32'hDEAD_BEEF, "R7");
    xfer(0, 6'h0B, 4'hF, 0, "R7");
    xfer(1, 6'h11, 4'h1, 32'hFFFF_FFFF, "R8");
    xfer(0, 6'h11, 4'hF, 0, "R8");
    xfer(1, 6'h0B, 4'h2, 32'h1111_ABCD, "R8");
    xfer(0, 6'h0B, 4'hF, 0, "R8");
    xfer(1, 6'h10, 4'h1, 32'h0000_5566, "R6");
    xfer(0, 6'h10, 4'hF, 0, "R6");
    xfer(0, 6'h0B, 4'hF, 0, "R6");
    xfer(1, 6'h0F, 4'h1, 32'h0000_0077, "R9");
    xfer(1, 6'h0F, 4'hE, 32'h9999_9999, "R9");
    xfer(0, 6'h0F, 4'hF, 0, "R9");
    xfer(1, 6'h11, 4'h1, 32'h0, "R8");
    xfer(1, 6'h0B, 4'hF, 32'h2222_3333, "R8");
    xfer(0, 6'h0B, 4'hF, 0, "R8");
    xfer(1, 6'h0C, 4'hF, 32'hFFFF_FFFF, "R10");
    for (int a = 0; a < 64; a++) xfer(0, 6'(a), 4'hF, 0, "R10");
    for (int i = 0; i < 600; i++) begin
      logic [5:0] a;
      a = ($urandom % 4 == 0) ? 6'($urandom) : 6'(8'h0B + ($urandom % 7));
      xfer(bit'($urandom % 2), a, 4'($urandom), $urandom, req_of(a));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule